// File: doc/BRIEF.md
# 16-bit Timer with Compare and Capture

This block is an up-counting 16-bit timer that software programs through a small 8-bit register bus. Eight clock-select codes set how the counter advances. It can stop, count every system clock, count on one of four prescaled rates, or count edges of an external pin. The block flags a wrap from 0xFFFF to 0x0000. One compare channel raises a flag when the count reaches a programmed value. That channel can also restart the count from zero and drive an output pin. One capture channel copies the count when a chosen edge arrives on a capture pin. An optional four-sample filter on that pin rejects short glitches.

Every 16-bit register is split into two byte addresses, and the two bytes share one holding byte. A write to a high byte only loads the holding byte. The next low-byte write commits all 16 bits in one cycle. A read of a low byte loads the holding byte with the matching high byte in that same cycle. So a high-byte read that follows returns a value consistent with the low byte, even while the counter moves. Each event has a sticky flag that software clears by writing 1. Each flag has a mask bit, and a set flag with its mask bit set drives an interrupt line.

Top module: `tmr16_cc`

## Requirements
- R1: Register map (byte addresses): 0 control, 1 interrupt mask, 2 flags, 3/4 counter low/high, 5/6 compare low/high, 7/8 capture low/high (read-only). Any other address reads 0. Control bits: [2:0] clock select, [3] clear-on-match, [5:4] pin mode, [6] capture edge, [7] filter enable. Mask and flag bits: [0] overflow, [1] compare, [2] capture. After reset every register reads 0, and cmp_out, cmp_out_en and irq are 0.
- R2: Clock select 000 holds the counter still. Clock select 001 adds one on every system clock.
- R3: Clock selects 010, 011, 100 and 101 add one every 8, 64, 256 and 1024 system clocks, respectively.
- R4: Clock select 110 counts falling edges of ext_clk_in, and 111 counts its rising edges. The pin passes through a two-flop synchroniser first.
- R5: A count step from 0xFFFF to 0x0000 sets the overflow flag.
- R6: A count step taken while the counter equals the compare value sets the compare flag. With clear-on-match set, that step loads 0 instead of incrementing, so the period is compare+1 steps. A compare value of 0xFFFF then returns the counter to 0 without setting the overflow flag.
- R7: On a compare match, pin mode 01 toggles cmp_out, 10 drives it to 0 and 11 drives it to 1. Mode 00 leaves cmp_out unchanged. cmp_out_en is 1 exactly when the mode is not 00.
- R8: On the capture edge chosen by control bit 6 (1 = rising, 0 = falling), the counter value is copied to the capture register and the capture flag is set. The other edge is ignored.
- R9: With the filter enabled, the capture pin's level is accepted only after four consecutive equal synchronised samples, so a two-clock pulse is ignored. With the filter off, the same pulse is captured.
- R10: Writing a high-byte address (4 or 6) only loads the shared holding byte. Writing the matching low byte commits {holding byte, written byte}. A high-byte write alone leaves the register unchanged.
- R11: Reading a low-byte address (3, 5 or 7) copies that register's high byte into the holding byte. Any high-byte read returns the holding byte, so a 16-bit read stays consistent across a carry into the high byte.
- R12: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. irq[i] is 1 exactly when flag i and mask bit i are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, marks a read for the holding-byte side effect |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ext_clk_in | input | 1 | Asynchronous external count pin |
| cap_in | input | 1 | Asynchronous capture pin |
| cmp_out | output | 1 | Compare output pin level |
| cmp_out_en | output | 1 | High when the compare pin is driven by the timer |
| irq | output | 3 | Interrupt requests: overflow, compare, capture |

## Verification
On every cycle, the embedded properties check these rules: a stopped counter holds its value, a wrap step raises the overflow flag, a clear-on-match step lands on zero, a capture stores the count of the edge cycle, and a write of 1 clears a flag. The directed scenarios are the only way to show prescaler ratios, external-edge counting through the synchroniser, and the atomic byte access. The same goes for the filter's rejection of short pulses and the pin-mode effects, since these only appear across several cycles of bus traffic.

// File: rtl/tmr16_cc.sv
`timescale 1ns/1ps
module tmr16_cc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ext_clk_in,
  input  logic       cap_in,
  output logic       cmp_out,
  output logic       cmp_out_en,
  output logic [2:0] irq
);
  localparam logic [3:0] A_CTRL = 4'd0, A_IEN = 4'd1, A_FLG = 4'd2,
                         A_CNT_L = 4'd3, A_CNT_H = 4'd4,
                         A_CMP_L = 4'd5, A_CMP_H = 4'd6,
                         A_CAP_L = 4'd7, A_CAP_H = 4'd8;
  localparam int PSC_W = 10;

  logic [7:0]  ctrl, tmp;
  logic [2:0]  ien, flg;
  logic [15:0] cnt, cmp, cap;
  logic [PSC_W-1:0] psc;
  logic [2:0]  xs;
  logic [1:0]  cs_q;
  logic [3:0]  hist;
  logic        cp_lvl, cp_prev;
  logic        tick, hit, wrap, cap_evt;

  wire [2:0] csel = ctrl[2:0];
  wire       ctc  = ctrl[3];
  wire [1:0] om   = ctrl[5:4];
  wire       ces  = ctrl[6];
  wire       cnc  = ctrl[7];

  wire wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  wire wr_ien   = bus_wr && bus_addr == A_IEN;
  wire wr_flg   = bus_wr && bus_addr == A_FLG;
  wire wr_cnt_l = bus_wr && bus_addr == A_CNT_L;
  wire wr_cmp_l = bus_wr && bus_addr == A_CMP_L;
  wire wr_hi    = bus_wr && (bus_addr == A_CNT_H || bus_addr == A_CMP_H);

  always_comb begin
    case (csel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &psc[2:0];
      3'd3:    tick = &psc[5:0];
      3'd4:    tick = &psc[7:0];
      3'd5:    tick = &psc[9:0];
      3'd6:    tick = ~xs[1] & xs[2];
      3'd7:    tick = xs[1] & ~xs[2];
      default: tick = 1'b0;
    endcase
  end

  assign hit     = tick && cnt == cmp;
  assign wrap    = tick && cnt == 16'hFFFF && !(hit && ctc);
  assign cap_evt = ces ? (cp_lvl & ~cp_prev) : (~cp_lvl & cp_prev);
  assign irq        = flg & ien;
  assign cmp_out_en = om != 2'b00;

  always_comb begin
    case (bus_addr)
      A_CTRL:                    bus_rdata = ctrl;
      A_IEN:                     bus_rdata = {5'd0, ien};
      A_FLG:                     bus_rdata = {5'd0, flg};
      A_CNT_L:                   bus_rdata = cnt[7:0];
      A_CMP_L:                   bus_rdata = cmp[7:0];
      A_CAP_L:                   bus_rdata = cap[7:0];
      A_CNT_H, A_CMP_H, A_CAP_H: bus_rdata = tmp;
      default:                   bus_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc <= '0; xs <= '0; cs_q <= '0; hist <= '0; cp_lvl <= 1'b0; cp_prev <= 1'b0;
    end else begin
      psc     <= psc + 1'b1;
      xs      <= {xs[1:0], ext_clk_in};
      cs_q    <= {cs_q[0], cap_in};
      hist    <= {hist[2:0], cs_q[1]};
      cp_prev <= cp_lvl;
      if (!cnc)          cp_lvl <= cs_q[1];
      else if (&hist)    cp_lvl <= 1'b1;
      else if (~|hist)   cp_lvl <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; ien <= '0; flg <= '0; tmp <= '0;
      cnt <= '0; cmp <= '0; cap <= '0; cmp_out <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata;
      if (wr_ien)  ien  <= bus_wdata[2:0];
      if (wr_hi) tmp <= bus_wdata;
      else if (bus_rd && bus_addr == A_CNT_L) tmp <= cnt[15:8];
      else if (bus_rd && bus_addr == A_CMP_L) tmp <= cmp[15:8];
      else if (bus_rd && bus_addr == A_CAP_L) tmp <= cap[15:8];
      if (wr_cnt_l)  cnt <= {tmp, bus_wdata};
      else if (tick) cnt <= (hit && ctc) ? 16'd0 : cnt + 16'd1;
      if (wr_cmp_l) cmp <= {tmp, bus_wdata};
      if (cap_evt)  cap <= cnt;
      flg <= (flg & ~(wr_flg ? bus_wdata[2:0] : 3'b000)) | {cap_evt, hit, wrap};
      if (hit) begin
        case (om)
          2'b01:   cmp_out <= ~cmp_out;
          2'b10:   cmp_out <= 1'b0;
          2'b11:   cmp_out <= 1'b1;
          default: cmp_out <= cmp_out;
        endcase
      end
    end
  end

  a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (csel == 3'd0 && !wr_cnt_l) |=> cnt == $past(cnt));
  a_r5_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == 16'hFFFF && !(ctc && cmp == 16'hFFFF)) |=> flg[0]);
  a_r6_ctc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctc && cnt == cmp && !wr_cnt_l) |=> cnt == 16'd0);
  a_r8_cap_value: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap == $past(cnt));
  a_r12_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flg && bus_wdata[2] && !cap_evt) |=> !flg[2]);
endmodule

// File: tb/tb_tmr16_cc.sv
`timescale 1ns/1ps
module tb_tmr16_cc;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic ext_clk_in = 0, cap_in = 0;
  logic cmp_out, cmp_out_en;
  logic [2:0] irq;
  int n_chk = 0, n_fail = 0;

  tmr16_cc dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk_in(ext_clk_in), .cap_in(cap_in), .cmp_out(cmp_out),
    .cmp_out_en(cmp_out_en), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
    wr(lo + 4'd1, v[15:8]);
    wr(lo, v[7:0]);
  endtask

  task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 4'd1, h);
    v = {h, l};
  endtask

  task automatic measure(input int n, output logic [15:0] d);
    logic [15:0] a, b;
    rd16(4'd3, a);
    repeat (n - 2) @(negedge clk);
    rd16(4'd3, b);
    d = b - a;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    logic [15:0] v;
    rd(4'd0, d);  chk(d == 0, "R1 ctrl reset", d, 0);
    rd(4'd2, d);  chk(d == 0, "R1 flags reset", d, 0);
    rd16(4'd3, v); chk(v == 0, "R1 counter reset", v, 0);
    rd16(4'd7, v); chk(v == 0, "R1 capture reset", v, 0);
    rd(4'd15, d); chk(d == 0, "R1 unmapped address", d, 0);
    chk({cmp_out, cmp_out_en, irq} == 0, "R1 outputs reset", {cmp_out, cmp_out_en, irq}, 0);
  endtask

  task automatic t_stop_div1;
    logic [15:0] d;
    wr16(4'd5, 16'h8000);
    wr16(4'd3, 16'h0100);
    measure(20, d); chk(d == 0, "R2 stopped", d, 0);
    wr(4'd0, 8'h01);
    measure(20, d); chk(d == 20, "R2 every clock", d, 20);
    wr(4'd0, 8'h00);
  endtask

  task automatic t_prescale;
    logic [15:0] d;
    for (int c = 2; c <= 5; c++) begin
      int dv;
      dv = (c == 2) ? 8 : (c == 3) ? 64 : (c == 4) ? 256 : 1024;
      wr(4'd0, 8'(c));
      measure(10 * dv, d);
      chk(d == 10, $sformatf("R3 divide by %0d", dv), d, 10);
    end
    wr(4'd0, 8'h00);
  endtask

  task automatic ext_pulses(input int k);
    for (int i = 0; i < k; i++) begin
      ext_clk_in = 1; idle(3);
      ext_clk_in = 0; idle(3);
    end
  endtask

  task automatic t_ext;
    logic [15:0] a, b;
    wr(4'd0, 8'h07);
    rd16(4'd3, a); ext_pulses(5); idle(6); rd16(4'd3, b);
    chk(b - a == 5, "R4 rising edges", b - a, 5);
    wr(4'd0, 8'h06);
    rd16(4'd3, a); ext_pulses(7); idle(6); rd16(4'd3, b);
    chk(b - a == 7, "R4 falling edges", b - a, 7);
    wr(4'd0, 8'h00);
  endtask

  task automatic t_wr16;
    logic [15:0] v;
    wr16(4'd5, 16'h1234);
    rd16(4'd5, v); chk(v == 16'h1234, "R10 compare write", v, 16'h1234);
    wr16(4'd3, 16'h4321);
    wr(4'd4, 8'h77);
    rd16(4'd3, v); chk(v == 16'h4321, "R10 high byte alone", v, 16'h4321);
    wr(4'd4, 8'h77);
    wr(4'd3, 8'h55);
    rd16(4'd3, v); chk(v == 16'h7755, "R10 commit on low byte", v, 16'h7755);
  endtask

  task automatic t_rd16;
    logic [15:0] v;
    wr16(4'd5, 16'h8000);
    wr16(4'd3, 16'h01FF);
    wr(4'd0, 8'h01);
    rd16(4'd3, v);
    wr(4'd0, 8'h00);
    chk(v == 16'h01FF, "R11 consistent read across carry", v, 16'h01FF);
  endtask

  task automatic t_ovf;
    logic [7:0] d;
    logic [15:0] v;
    wr(4'd2, 8'h07); wr(4'd1, 8'h00);
    wr16(4'd5, 16'h1000);
    wr16(4'd3, 16'hFFFD);
    wr(4'd0, 8'h01); idle(6); wr(4'd0, 8'h00);
    rd16(4'd3, v); chk(v == 16'h0004, "R5 wrapped count", v, 4);
    rd(4'd2, d); chk(d[0] == 1, "R5 overflow flag", d, 1);
    chk(irq[0] == 0, "R12 masked irq", irq, 0);
    wr(4'd1, 8'h01); chk(irq[0] == 1, "R12 irq with mask", irq, 1);
    wr(4'd2, 8'h00);
    rd(4'd2, d); chk(d[0] == 1, "R12 writing 0 keeps flag", d, 1);
    wr(4'd2, 8'h01);
    rd(4'd2, d); chk(d[0] == 0, "R12 write 1 clears", d, 0);
    chk(irq == 0, "R12 irq drops", irq, 0);
    wr(4'd1, 8'h00);
  endtask

  task automatic t_ctc;
    logic [7:0] d;
    logic [15:0] v;
    int tog;
    logic p;
    wr(4'd2, 8'h07);
    wr16(4'd5, 16'd4); wr16(4'd3, 16'd0);
    wr(4'd0, 8'h19);
    tog = 0; p = cmp_out;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (cmp_out != p) tog++;
      p = cmp_out;
    end
    wr(4'd0, 8'h10);
    chk(tog == 10, "R7 toggle every match, R6 period 5", tog, 10);
    rd16(4'd3, v); chk(v <= 4, "R6 count stays below compare", v, 4);
    rd(4'd2, d); chk(d[1:0] == 2'b10, "R6 compare flag, no overflow", d, 2);
    wr(4'd2, 8'h07);
    wr16(4'd5, 16'hFFFF); wr16(4'd3, 16'hFFFC);
    wr(4'd0, 8'h09); idle(10); wr(4'd0, 8'h00);
    rd16(4'd3, v); chk(v == 16'd7, "R6 clear at 0xFFFF", v, 7);
    rd(4'd2, d); chk(d[1:0] == 2'b10, "R6 no overflow on clear at 0xFFFF", d, 2);
  endtask

  task automatic t_pin;
    wr16(4'd5, 16'd2); wr16(4'd3, 16'd0);
    wr(4'd0, 8'h39); idle(10); wr(4'd0, 8'h30);
    chk(cmp_out == 1 && cmp_out_en == 1, "R7 set mode", {cmp_out, cmp_out_en}, 3);
    wr16(4'd3, 16'd0);
    wr(4'd0, 8'h09); idle(10); wr(4'd0, 8'h00);
    chk(cmp_out == 1 && cmp_out_en == 0, "R7 mode 00 leaves pin", {cmp_out, cmp_out_en}, 2);
    wr16(4'd3, 16'd0);
    wr(4'd0, 8'h29); idle(10); wr(4'd0, 8'h20);
    chk(cmp_out == 0 && cmp_out_en == 1, "R7 clear mode", {cmp_out, cmp_out_en}, 1);
    wr(4'd0, 8'h00);
  endtask

  task automatic t_capture;
    logic [7:0] d;
    logic [15:0] v;
    wr(4'd2, 8'h07);
    wr16(4'd3, 16'hABCD); wr(4'd0, 8'h40);
    cap_in = 1; idle(6);
    rd16(4'd7, v); chk(v == 16'hABCD, "R8 rising capture value", v, 16'hABCD);
    rd(4'd2, d); chk(d[2] == 1, "R8 capture flag", d, 4);
    wr(4'd2, 8'h04);
    wr16(4'd3, 16'h1111);
    cap_in = 0; idle(6);
    rd16(4'd7, v); chk(v == 16'hABCD, "R8 other edge ignored", v, 16'hABCD);
    rd(4'd2, d); chk(d[2] == 0, "R8 no flag on other edge", d, 0);
    wr(4'd0, 8'h00);
    wr16(4'd3, 16'h2222);
    cap_in = 1; idle(6);
    rd16(4'd7, v); chk(v == 16'hABCD, "R8 rising ignored in falling mode", v, 16'hABCD);
    cap_in = 0; idle(6);
    rd16(4'd7, v); chk(v == 16'h2222, "R8 falling capture", v, 16'h2222);
  endtask

  task automatic t_filter;
    logic [7:0] d;
    logic [15:0] v;
    wr(4'd0, 8'hC0); idle(8);
    wr(4'd2, 8'h07);
    wr16(4'd3, 16'h3333);
    cap_in = 1; idle(2); cap_in = 0; idle(8);
    rd16(4'd7, v); chk(v == 16'h2222, "R9 short pulse rejected", v, 16'h2222);
    rd(4'd2, d); chk(d[2] == 0, "R9 no flag on short pulse", d, 0);
    wr16(4'd3, 16'h4444);
    cap_in = 1; idle(8);
    rd16(4'd7, v); chk(v == 16'h4444, "R9 steady level captured", v, 16'h4444);
    cap_in = 0; idle(8);
    wr(4'd0, 8'h40); idle(4);
    wr(4'd2, 8'h07);
    wr16(4'd3, 16'h5555);
    cap_in = 1; idle(2); cap_in = 0; idle(8);
    rd16(4'd7, v); chk(v == 16'h5555, "R9 short pulse passes unfiltered", v, 16'h5555);
    wr(4'd0, 8'h00);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_stop_div1;
    t_prescale;
    t_ext;
    t_wr16;
    t_rd16;
    t_ovf;
    t_ctc;
    t_pin;
    t_capture;
    t_filter;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule